// File: doc/BRIEF.md
# SWD Host Transaction Engine

This block is the host side of one serial-wire debug access. A requester hands it a single command: whether the access goes to an access port or to the debug port, whether it reads or writes, a two-bit register address, and, for a write, a 32-bit word. The engine then generates the debug clock itself. It shifts out the request header and releases the shared data pin for the turnaround. It collects the target's three-bit acknowledge and, when the target answered OK, moves the data word in the proper direction. It finishes with a response that carries the acknowledge code, the read word and a parity-error flag.

The data pin is handled as a split output, output-enable and input triple, so the pad cell sits outside the block. The host changes the pin only while the debug clock falls and samples the target only while the clock rises. Between transactions the clock idles low and the host drives the line low. The debug clock rate is set by a parameter that counts system clocks per half period. Retry after WAIT, abort handling and any address sequencing are left to the requester.

Top module: `swd_host_engine`

## Requirements
- R1: The header is 8 bits, sent first to last as: a 1, the port select (1 = access port, 0 = debug port), the direction (1 = read, 0 = write), address bit 0, address bit 1, the header parity, a 0, and a final 1.
- R2: The header parity bit is 1 exactly when the port select, direction and both address bits together hold an odd count of ones.
- R3: After the header the host releases the pin (output enable 0) for one clock period, then keeps it released while it samples 3 acknowledge bits, the first received bit being bit 0 of the code; OK is 3'b001, WAIT 3'b010, FAULT 3'b100.
- R4: On a write acknowledged OK, one released turnaround period follows, then the host drives 32 data bits least significant first and then their parity bit (1 when the word holds an odd count of ones).
- R5: On a read acknowledged OK, the host samples 32 data bits least significant first and a parity bit, returns the word in the response, then releases the pin for one turnaround period before driving it again.
- R6: The response parity-error flag is 1 only for a read acknowledged OK whose received parity bit differs from the parity of the received word.
- R7: Any acknowledge other than OK (WAIT, FAULT or an unrecognised code) skips the data phase, is followed by one released turnaround period, and is returned unchanged with a zero read word and a clear parity flag.
- R8: The data pin and its enable change only while the debug clock falls (or when a command is accepted), the debug clock rests low between transactions, and the idle line is driven low.
- R9: The command port is ready only while no transaction is in progress; a command is taken when valid and ready are both high, and the response valid is a one-cycle pulse per command.
- R10: After reset the debug clock is low, the data pin is driven low, the command port is ready and no response is valid.
- R11: Each debug clock period lasts 2 x HALF_PERIOD system clocks, with the clock high for HALF_PERIOD of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_ap | input | 1 | 1 = access port, 0 = debug port |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits (bit 0 sent first) |
| cmd_wdata | input | 32 | Word to write |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ack | output | 3 | Acknowledge code as received |
| resp_rdata | output | 32 | Word read (zero unless an OK read) |
| resp_perr | output | 1 | Read data parity mismatch |
| swclk | output | 1 | Debug clock to the target |
| swdio_o | output | 1 | Data pin value driven by the host |
| swdio_oe | output | 1 | Data pin output enable |
| swdio_i | input | 1 | Data pin value seen from the line |

## Verification
The bench builds the engine with HALF_PERIOD = 3. That gives a real divider with distinct rising and falling moments several system clocks apart. Stray pin changes between clock edges, and an off-by-one in the period, therefore become visible at the ports. The default setting of one system clock per half period would hide both. A behavioural target in the bench answers OK, WAIT, FAULT and a floating-high code, and returns read words with good and corrupted parity. Header parity of both values and all-zero and all-one data words are covered.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

    localparam int WORD_W = 32;
    localparam int HDR_W  = 8;
    localparam int ACK_W  = 3;

    localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
    localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
    localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_TRN1,
        ST_ACK,
        ST_WDATA,
        ST_RDATA,
        ST_TRN2,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic              ap;
        logic              rd;
        logic [1:0]        addr;
        logic [WORD_W-1:0] wdata;
    } swd_req_t;

    typedef struct packed {
        logic [ACK_W-1:0]  ack;
        logic [WORD_W-1:0] rdata;
        logic              perr;
    } swd_resp_t;

    // Header in shift order: bit 0 leaves the pin first.
    function automatic logic [HDR_W-1:0] hdr_build(input swd_req_t r);
        logic par;
        par = r.ap ^ r.rd ^ r.addr[0] ^ r.addr[1];
        return {1'b1, 1'b0, par, r.addr[1], r.addr[0], r.rd, r.ap, 1'b1};
    endfunction

    function automatic logic word_par(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
    parameter int HALF_PERIOD = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic swclk,
    output logic rise_tick,
    output logic fall_tick
);
    logic clk_q;
    logic wrap;

    generate
        if (HALF_PERIOD <= 1) begin : g_direct
            assign wrap = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_PERIOD);
            localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);
            logic [CW-1:0] cnt_q;

            assign wrap = run && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt_q <= '0;
                end else if (wrap) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

    assign rise_tick = wrap && !clk_q;
    assign fall_tick = wrap &&  clk_q;
    assign swclk     = clk_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            clk_q <= 1'b0;
        end else if (wrap) begin
            clk_q <= !clk_q;
        end
    end

    // R11: the debug clock level only moves on a divider wrap.
    assert_clock_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (!rise_tick && !fall_tick) |=> $stable(swclk));

    // R8: the clock rests low whenever the engine is not running.
    assert_idle_clock_low_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> !swclk);

endmodule

// File: rtl/swd_frame_ctrl.sv
module swd_frame_ctrl
    import swd_host_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rise_tick,
    input  logic      fall_tick,
    output logic      run,
    input  logic      cmd_valid,
    output logic      cmd_ready,
    input  swd_req_t  req,
    output logic      resp_valid,
    output swd_resp_t resp,
    output logic      swdio_o,
    output logic      swdio_oe,
    input  logic      swdio_i
);
    localparam int CNT_W     = $clog2(WORD_W + 1) + 1;
    localparam int LAST_HDR  = HDR_W - 1;
    localparam int LAST_ACK  = ACK_W - 1;
    localparam int LAST_DATA = WORD_W;

    seq_state_t         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [HDR_W-1:0]   hdr_q;
    logic [WORD_W:0]    wsh_q;
    logic [WORD_W:0]    rsh_q;
    logic [ACK_W-1:0]   ack_q;
    logic [ACK_W-1:0]   ack_next;
    logic               rd_q;
    logic               accept;
    logic               ack_ok;
    logic               drv_oe;
    logic               drv_o;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign run       = (state_q != ST_IDLE);
    assign ack_next  = {swdio_i, ack_q[ACK_W-1:1]};
    assign ack_ok    = (ack_q == ACK_OK);

    // Pin values for the slot the state machine now sits in.
    always_comb begin
        drv_oe = 1'b1;
        drv_o  = 1'b0;
        case (state_q)
            ST_HDR:   drv_o  = hdr_q[0];
            ST_WDATA: drv_o  = wsh_q[0];
            ST_TRN1, ST_ACK, ST_RDATA, ST_TRN2: drv_oe = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            hdr_q      <= '0;
            wsh_q      <= '0;
            rsh_q      <= '0;
            ack_q      <= '0;
            rd_q       <= 1'b0;
            swdio_o    <= 1'b0;
            swdio_oe   <= 1'b1;
            resp_valid <= 1'b0;
            resp       <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (accept) begin
                hdr_q    <= hdr_build(req);
                wsh_q    <= {word_par(req.wdata), req.wdata};
                rsh_q    <= '0;
                ack_q    <= '0;
                rd_q     <= req.rd;
                cnt_q    <= '0;
                state_q  <= ST_HDR;
                swdio_o  <= 1'b1;
                swdio_oe <= 1'b1;
            end else if (rise_tick) begin
                case (state_q)
                    ST_HDR: begin
                        hdr_q <= hdr_q >> 1;
                        if (cnt_q == CNT_W'(LAST_HDR)) begin
                            cnt_q   <= '0;
                            state_q <= ST_TRN1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_TRN1: begin
                        cnt_q   <= '0;
                        state_q <= ST_ACK;
                    end
                    ST_ACK: begin
                        ack_q <= ack_next;
                        if (cnt_q == CNT_W'(LAST_ACK)) begin
                            cnt_q   <= '0;
                            state_q <= (ack_next == ACK_OK && rd_q) ? ST_RDATA : ST_TRN2;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        rsh_q <= {swdio_i, rsh_q[WORD_W:1]};
                        if (cnt_q == CNT_W'(LAST_DATA)) begin
                            cnt_q   <= '0;
                            state_q <= ST_TRN2;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_TRN2: begin
                        cnt_q   <= '0;
                        state_q <= (ack_ok && !rd_q) ? ST_WDATA : ST_DONE;
                    end
                    ST_WDATA: begin
                        wsh_q <= wsh_q >> 1;
                        if (cnt_q == CNT_W'(LAST_DATA)) begin
                            cnt_q   <= '0;
                            state_q <= ST_DONE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (fall_tick) begin
                swdio_oe <= drv_oe;
                swdio_o  <= drv_o;
                if (state_q == ST_DONE) begin
                    state_q    <= ST_IDLE;
                    resp_valid <= 1'b1;
                    resp.ack   <= ack_q;
                    resp.rdata <= (ack_ok && rd_q) ? rsh_q[WORD_W-1:0] : '0;
                    resp.perr  <= ack_ok && rd_q &&
                                  (word_par(rsh_q[WORD_W-1:0]) != rsh_q[WORD_W]);
                end
            end
        end
    end

    // R8: pins move only on a falling debug clock or on command acceptance.
    assert_pins_move_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        (!fall_tick && !accept) |=> ($stable(swdio_oe) && $stable(swdio_o)));

    // R3: the host never drives while the target owns the line.
    assert_line_released_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACK || state_q == ST_RDATA) |-> !swdio_oe);

    // R9: each response strobe lasts one cycle.
    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R6: a parity error is only ever reported with an OK acknowledge.
    assert_perr_needs_ok_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp.perr) |-> (resp.ack == ACK_OK));

    // R9: no command is taken while a transaction runs.
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !cmd_ready);

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swd_host_pkg::*;
#(
    parameter int HALF_PERIOD = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic        cmd_ap,
    input  logic        cmd_read,
    input  logic [1:0]  cmd_addr,
    input  logic [31:0] cmd_wdata,
    output logic        resp_valid,
    output logic [2:0]  resp_ack,
    output logic [31:0] resp_rdata,
    output logic        resp_perr,
    output logic        swclk,
    output logic        swdio_o,
    output logic        swdio_oe,
    input  logic        swdio_i
);
    swd_req_t  req;
    swd_resp_t resp;
    logic      run;
    logic      rise_tick;
    logic      fall_tick;

    assign req = '{ap: cmd_ap, rd: cmd_read, addr: cmd_addr, wdata: cmd_wdata};

    assign resp_ack   = resp.ack;
    assign resp_rdata = resp.rdata;
    assign resp_perr  = resp.perr;

    swd_clk_div #(
        .HALF_PERIOD (HALF_PERIOD)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .swclk     (swclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    swd_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .run        (run),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .req        (req),
        .resp_valid (resp_valid),
        .resp       (resp),
        .swdio_o    (swdio_o),
        .swdio_oe   (swdio_oe),
        .swdio_i    (swdio_i)
    );

endmodule

// File: tb/swd_host_engine_test.sv
`timescale 1ns/1ps
module swd_host_engine_test;
    localparam int  HP     = 3;
    localparam real TCLK   = 5.0;

    typedef struct {
        logic [2:0]  ack;
        logic [31:0] rdata;
        logic        perr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_ap = 1'b0;
    logic        cmd_read = 1'b0;
    logic [1:0]  cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        resp_valid;
    logic [2:0]  resp_ack;
    logic [31:0] resp_rdata;
    logic        resp_perr;
    logic        swclk;
    logic        swdio_o;
    logic        swdio_oe;
    logic        swdio_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    swd_host_engine #(.HALF_PERIOD(HP)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_ap(cmd_ap), .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_rdata(resp_rdata),
        .resp_perr(resp_perr),
        .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare each response strobe against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(resp_ack == e.ack, {e.tag, " ack"}, resp_ack, e.ack);
                chk(resp_rdata == e.rdata, {e.tag, " rdata"}, resp_rdata, e.rdata);
                chk(resp_perr == e.perr, {e.tag, " perr R6"}, resp_perr, e.perr);
            end
        end
    end

    // Driver plus behavioural target for one access.
    task automatic run_txn(input logic ap, input logic rd, input logic [1:0] addr,
                           input logic [31:0] wdata, input logic [2:0] tgt_ack,
                           input logic [31:0] tgt_data, input bit bad_par,
                           input string tag);
        exp_t        e;
        logic [7:0]  hdr_exp;
        logic [7:0]  hdr_got;
        logic [32:0] wr_got;
        logic        ok;
        logic        pre;
        realtime     t0;
        realtime     t1;
        ok = (tgt_ack == 3'b001);
        hdr_exp = {1'b1, 1'b0, ap ^ rd ^ addr[0] ^ addr[1], addr[1], addr[0], rd, ap, 1'b1};
        e.ack   = tgt_ack;
        e.rdata = (ok && rd) ? tgt_data : 32'h0;
        e.perr  = ok && rd && bad_par;
        e.tag   = tag;
        sb_q.push_back(e);

        @(negedge clk);
        cmd_ap = ap; cmd_read = rd; cmd_addr = addr; cmd_wdata = wdata;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R9 busy after accept", cmd_ready, 0);

        t0 = 0.0;
        for (int j = 0; j < 8; j++) begin
            if (j > 0) begin
                @(negedge swclk);
                #1;
                pre = swdio_o;
            end
            @(posedge swclk);
            if (j == 0) t0 = $realtime;
            if (j == 1) begin
                t1 = $realtime;
                chk((t1 - t0) > (2*HP*TCLK - 0.01) && (t1 - t0) < (2*HP*TCLK + 0.01),
                    "R11 period", 64'(int'(t1 - t0)), 64'(int'(2*HP*TCLK)));
            end
            hdr_got[j] = swdio_o;
            if (!swdio_oe) chk(1'b0, "R1 header not driven", swdio_oe, 1);
            if (j > 0 && pre != swdio_o) chk(1'b0, "R8 pin moved mid-period", swdio_o, pre);
        end
        chk(hdr_got == hdr_exp, {tag, " R1 R2 header"}, hdr_got, hdr_exp);

        // Turnaround: junk on the line must be ignored.
        @(negedge swclk);
        swdio_i = 1'b1;
        @(posedge swclk);
        chk(swdio_oe == 1'b0, "R3 turnaround released", swdio_oe, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge swclk);
            swdio_i = tgt_ack[k];
            @(posedge swclk);
            if (swdio_oe) chk(1'b0, "R3 driven during ack", swdio_oe, 0);
        end

        if (ok && rd) begin
            for (int k = 0; k < 33; k++) begin
                @(negedge swclk);
                swdio_i = (k < 32) ? tgt_data[k] : ((^tgt_data) ^ bad_par);
                @(posedge swclk);
                if (swdio_oe) chk(1'b0, "R5 driven during read data", swdio_oe, 0);
            end
            @(negedge swclk);
            swdio_i = 1'b0;
            @(posedge swclk);
            chk(swdio_oe == 1'b0, "R5 turnaround after read", swdio_oe, 0);
            @(negedge swclk);
            #1;
            chk(swdio_oe == 1'b1 && swdio_o == 1'b0, "R5 host drives again",
                {swdio_oe, swdio_o}, 2'b10);
        end else if (ok) begin
            @(negedge swclk);
            swdio_i = 1'b0;
            @(posedge swclk);
            chk(swdio_oe == 1'b0, "R4 turnaround before write", swdio_oe, 0);
            for (int k = 0; k < 33; k++) begin
                @(posedge swclk);
                wr_got[k] = swdio_o;
                if (!swdio_oe) chk(1'b0, "R4 write data not driven", swdio_oe, 1);
            end
            chk(wr_got == {^wdata, wdata}, {tag, " R4 write word"}, wr_got, {^wdata, wdata});
        end else begin
            @(negedge swclk);
            swdio_i = 1'b0;
            @(posedge swclk);
            chk(swdio_oe == 1'b0, "R7 turnaround after refusal", swdio_oe, 0);
            @(negedge swclk);
            #1;
            chk(swdio_oe == 1'b1 && swdio_o == 1'b0, "R7 no data phase",
                {swdio_oe, swdio_o}, 2'b10);
        end

        wait (sb_q.size() == 0);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9 single-cycle response", resp_valid, 0);
        chk(cmd_ready == 1'b1, "R9 ready when idle", cmd_ready, 1);
        chk(swclk == 1'b0 && swdio_oe == 1'b1 && swdio_o == 1'b0, "R8 idle line",
            {swclk, swdio_oe, swdio_o}, 3'b010);
    endtask

    task automatic run_all();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(swclk == 1'b0, "R10 clock low", swclk, 0);
        chk(swdio_oe == 1'b1 && swdio_o == 1'b0, "R10 line driven low",
            {swdio_oe, swdio_o}, 2'b10);
        chk(cmd_ready == 1'b1, "R10 ready", cmd_ready, 1);
        chk(resp_valid == 1'b0, "R10 no response", resp_valid, 0);
        repeat (3) @(negedge clk);
        chk(swclk == 1'b0, "R8 clock rests while idle", swclk, 0);

        run_txn(1'b0, 1'b1, 2'd0, 32'h0, 3'b001, 32'h2BA0_1477, 1'b0, "R5 DP read");
        run_txn(1'b1, 1'b0, 2'd3, 32'hDEAD_BEEF, 3'b001, 32'h0, 1'b0, "R4 AP write");
        run_txn(1'b1, 1'b1, 2'd1, 32'h0, 3'b001, 32'h1234_5671, 1'b1, "R6 bad parity");
        run_txn(1'b0, 1'b0, 2'd2, 32'h5555_AAAA, 3'b010, 32'h0, 1'b0, "R7 WAIT write");
        run_txn(1'b1, 1'b1, 2'd2, 32'h0, 3'b100, 32'hFFFF_0000, 1'b0, "R7 FAULT read");
        run_txn(1'b0, 1'b1, 2'd1, 32'h0, 3'b111, 32'hCAFE_F00D, 1'b0, "R7 no target");
        run_txn(1'b0, 1'b1, 2'd3, 32'h0, 3'b001, 32'hFFFF_FFFF, 1'b0, "R5 all ones");
        run_txn(1'b1, 1'b0, 2'd0, 32'h0000_0000, 3'b001, 32'h0, 1'b0, "R4 zero word");
        run_txn(1'b0, 1'b0, 2'd1, 32'h8000_0001, 3'b001, 32'h0, 1'b0, "R2 odd header");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule